// File: doc/BRIEF.md
# Quad-Channel Serial DAC Write Sequencer

This block feeds a four-channel serial DAC from a stream of sample sets. Each sample set holds four 16-bit codes and arrives over a valid/ready handshake. The block turns every channel update into one 24-bit serial frame. Each frame is framed by an active-low chip select (`cs_n`), clocked by a divided serial clock (`sclk`) and carried on `sdin`. Between frames, chip select is held high for a guaranteed minimum time.

In group mode all four channels are written in ascending order. A single low pulse on the load strobe (`ldac_n`) then moves the four new codes to the analog outputs together. In single mode only one channel is written: the lowest-numbered channel set in the enable mask. The load strobe stays low in this mode, so each frame takes effect as soon as it closes. The single channel can therefore be rewritten at the full frame rate. Channels that are not addressed receive no frame and keep whatever they last loaded.

The serial clock half-period, the chip-select gap, the load delay and the load width are all parameters counted in system clock cycles. A controller built around states IDLE, SHIFT, GAP, LWAIT and LPULSE runs the sequence:
- IDLE goes to SHIFT when a sample set is held.
- SHIFT goes to GAP at the end of a frame. At the end of the fourth frame of a group run it goes to LWAIT instead.
- GAP goes to SHIFT for the next frame of a group run, or to SHIFT for a newly held set, or otherwise back to IDLE.
- LWAIT goes to LPULSE when the load delay expires.
- LPULSE goes to GAP when the pulse width expires.

Top module: `quad_dac_sequencer`

## Requirements
- R1: After reset, `cs_n`, `ldac_n` and `sclk` are high, `sdin` is low and `smp_ready` is high. No frame is sent until a sample set has been accepted.
- R2: Every chip-select low window contains exactly 24 falling `sclk` edges. The word is sent MSB first and laid out as follows: bit 23 is 0 (write), bits 22:19 are 0000 (data register select), bits 18:16 hold the channel number, and bits 15:0 hold the channel's code.
- R3: `sclk` is high whenever `cs_n` is high. Within a frame, `sdin` only changes while `sclk` is high, so it is stable for the falling edge on which the DAC samples. Each `sclk` half-period lasts SCLK_HALF clock cycles.
- R4: Between two consecutive frames, `cs_n` stays high for at least GAP_CYC clock cycles.
- R5: A group-mode sample set produces four frames, addressed to channels 0, 1, 2 and 3 in that order, whatever the enable mask says. `ldac_n` is high during these frames.
- R6: After the fourth frame of a group run, `ldac_n` falls exactly LDAC_DLY cycles after `cs_n` rises. It stays low for exactly LDAC_W cycles, and `cs_n` is high throughout the pulse.
- R7: A single-mode sample set produces exactly one frame, addressed to the lowest-numbered enabled channel, or to channel 0 when the mask is empty. The other codes are not sent. `ldac_n` is low from the start of that frame until a group-mode set begins.
- R8: `smp_ready` is high only when no set is already held and the block is either idle or sending the last frame of its run. Mode and mask are captured at acceptance. Every accepted set is sent in full and in acceptance order.
- R9: With sets offered continuously, single-mode frames start every 48·SCLK_HALF+GAP_CYC cycles. Group runs start every 4·48·SCLK_HALF+3·GAP_CYC+LDAC_DLY+LDAC_W+GAP_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample set is offered |
| smp_ready | output | 1 | The block takes the offered set on this edge |
| smp_codes | input | 64 | Four 16-bit codes, channel n in bits 16n+15:16n |
| single_mode | input | 1 | 1 = write one enabled channel per set, 0 = write all four then load |
| chan_en | input | 4 | Channel enable mask used in single mode |
| sclk | output | 1 | Serial clock, idles high, DAC samples on its falling edge |
| sdin | output | 1 | Serial data, MSB first |
| cs_n | output | 1 | Active-low frame select |
| ldac_n | output | 1 | Active-low load strobe |

## Verification
The bench decodes frames from the pins the way the DAC would. It goes after several faults, each of which it would see at the pins:
- If the gap after a frame were cut short or skipped before the load pulse, the measured chip-select high time would fall below the minimum.
- An off-by-one in the load timer would move the load pulse by a cycle or change its width.
- A wrong priority in the mask search would address the wrong channel in single mode.
- If the handshake accepted a set in the middle of a group, the remaining frames of that group would carry the new codes.

Back-to-back streaming in both modes pins down the frame and run periods. Any idle cycle lost between a held set and the next frame would change those periods.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    // Header byte ahead of the code: write bit, pad, register select, channel address
    localparam int HDR_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SHIFT,
        S_GAP,
        S_LWAIT,
        S_LPULSE
    } seq_state_t;

endpackage

// File: rtl/dac_frame_shifter.sv
// Shifts one word out MSB first. sclk idles high; the far side samples on the
// falling edge and sdin moves together with the rising edge.
module dac_frame_shifter #(
    parameter int FW   = 24,
    parameter int HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FW-1:0] word,
    output logic          sclk,
    output logic          sdin,
    output logic          done
);
    localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = $clog2(FW);

    logic          active;
    logic          lo;
    logic [PW-1:0] ph;
    logic [BW-1:0] bitn;
    logic [FW-1:0] sh;
    logic          half_end;

    assign half_end = active && (ph == PW'(HALF - 1));
    assign done     = half_end && lo && (bitn == BW'(FW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            lo     <= 1'b0;
            ph     <= '0;
            bitn   <= '0;
            sh     <= '0;
        end else if (start) begin
            active <= 1'b1;
            lo     <= 1'b0;
            ph     <= '0;
            bitn   <= '0;
            sh     <= word;
        end else if (active) begin
            if (half_end) begin
                ph <= '0;
                if (!lo) begin
                    lo <= 1'b1;
                end else begin
                    lo <= 1'b0;
                    if (bitn == BW'(FW - 1)) begin
                        active <= 1'b0;
                    end else begin
                        bitn <= bitn + 1'b1;
                        sh   <= {sh[FW-2:0], 1'b0};
                    end
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    assign sclk = !(active && lo);
    assign sdin = active && sh[FW-1];

endmodule

// File: rtl/dac_cycle_timer.sv
// Loadable down-counter; expired is high once the loaded count has run out.
module dac_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= len;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/quad_dac_sequencer.sv
module quad_dac_sequencer
    import dac_seq_pkg::*;
#(
    parameter int CODE_W    = 16,
    parameter int N_CH      = 4,
    parameter int SCLK_HALF = 2,
    parameter int GAP_CYC   = 17,
    parameter int LDAC_DLY  = 13,
    parameter int LDAC_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    output logic                   smp_ready,
    input  logic [N_CH*CODE_W-1:0] smp_codes,
    input  logic                   single_mode,
    input  logic [N_CH-1:0]        chan_en,
    output logic                   sclk,
    output logic                   sdin,
    output logic                   cs_n,
    output logic                   ldac_n
);
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int FW   = HDR_W + CODE_W;
    localparam int T1   = (GAP_CYC > LDAC_DLY) ? GAP_CYC : LDAC_DLY;
    localparam int TMAX = (T1 > LDAC_W) ? T1 : LDAC_W;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_t              state, state_n;
    logic [N_CH*CODE_W-1:0]  cur;
    logic                    cur_single;
    logic [N_CH-1:0]         cur_mask;
    logic                    have;
    logic                    run_grp;
    logic [CH_W-1:0]         run_ch;
    logic [CH_W-1:0]         load_ch;
    logic                    ldac_q;
    logic                    last_frame;
    logic                    accept;
    logic                    start_run;
    logic                    next_frame;
    logic                    frame_done;
    logic                    tload;
    logic [TW-1:0]           tlen;
    logic                    t_exp;
    logic [FW-1:0]           word;

    function automatic logic [CH_W-1:0] lowest_en(input logic [N_CH-1:0] m);
        lowest_en = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (m[i]) lowest_en = CH_W'(i);
        end
    endfunction

    assign last_frame = !run_grp || (run_ch == CH_W'(N_CH - 1));
    assign smp_ready  = !have && ((state == S_IDLE) || ((state == S_SHIFT) && last_frame));
    assign accept     = smp_valid && smp_ready;

    always_comb begin
        if (start_run) load_ch = cur_single ? lowest_en(cur_mask) : '0;
        else           load_ch = run_ch + 1'b1;
    end

    assign word = {5'b00000, 3'(load_ch), cur[int'(load_ch)*CODE_W +: CODE_W]};

    // next-state and timer control
    always_comb begin
        state_n    = state;
        start_run  = 1'b0;
        next_frame = 1'b0;
        tload      = 1'b0;
        tlen       = '0;
        unique case (state)
            S_IDLE: begin
                if (have) begin
                    state_n   = S_SHIFT;
                    start_run = 1'b1;
                end
            end
            S_SHIFT: begin
                if (frame_done) begin
                    tload = 1'b1;
                    if (run_grp && last_frame) begin
                        state_n = S_LWAIT;
                        tlen    = TW'(LDAC_DLY - 1);
                    end else begin
                        state_n = S_GAP;
                        tlen    = TW'(GAP_CYC - 1);
                    end
                end
            end
            S_GAP: begin
                if (t_exp) begin
                    if (run_grp && !last_frame) begin
                        state_n    = S_SHIFT;
                        next_frame = 1'b1;
                    end else if (have) begin
                        state_n   = S_SHIFT;
                        start_run = 1'b1;
                    end else begin
                        state_n = S_IDLE;
                    end
                end
            end
            S_LWAIT: begin
                if (t_exp) begin
                    state_n = S_LPULSE;
                    tload   = 1'b1;
                    tlen    = TW'(LDAC_W - 1);
                end
            end
            S_LPULSE: begin
                if (t_exp) begin
                    state_n = S_GAP;
                    tload   = 1'b1;
                    tlen    = TW'(GAP_CYC - 1);
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // held sample set and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur        <= '0;
            cur_single <= 1'b0;
            cur_mask   <= '0;
            have       <= 1'b0;
            run_grp    <= 1'b0;
            run_ch     <= '0;
            ldac_q     <= 1'b1;
        end else begin
            if (accept) begin
                cur        <= smp_codes;
                cur_single <= single_mode;
                cur_mask   <= chan_en;
                have       <= 1'b1;
            end else if (start_run) begin
                have <= 1'b0;
            end
            if (start_run) begin
                run_grp <= !cur_single;
                run_ch  <= load_ch;
                ldac_q  <= !cur_single;
            end else if (next_frame) begin
                run_ch <= load_ch;
            end
        end
    end

    dac_frame_shifter #(.FW(FW), .HALF(SCLK_HALF)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_run || next_frame),
        .word  (word),
        .sclk  (sclk),
        .sdin  (sdin),
        .done  (frame_done)
    );

    dac_cycle_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tload),
        .len     (tlen),
        .expired (t_exp)
    );

    // outputs
    always_comb begin
        cs_n   = (state != S_SHIFT);
        ldac_n = ldac_q && (state != S_LPULSE);
    end

endmodule

// File: rtl/quad_dac_sequencer_chk.sv
module quad_dac_sequencer_chk #(
    parameter int FW      = 24,
    parameter int GAP_CYC = 17,
    parameter int LDAC_W  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdin,
    input logic ldac_n,
    input logic smp_valid,
    input logic smp_ready,
    input logic run_grp
);
    logic [7:0] hi_cnt;
    logic [7:0] fall_cnt;
    logic [7:0] lo_w;
    logic       sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= 8'd255;
            fall_cnt <= '0;
            lo_w     <= '0;
            sclk_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            if (cs_n) hi_cnt <= (hi_cnt == 8'd255) ? hi_cnt : hi_cnt + 1'b1;
            else      hi_cnt <= '0;
            if (cs_n)                  fall_cnt <= '0;
            else if (sclk_q && !sclk)  fall_cnt <= fall_cnt + 1'b1;
            if (!ldac_n) lo_w <= (lo_w == 8'd255) ? lo_w : lo_w + 1'b1;
            else         lo_w <= '0;
        end
    end

    // R2: one frame is exactly FW falling clock edges
    a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (fall_cnt == 8'(FW)));

    // R3: clock parked high outside frames
    a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R3: data held while clock is low
    a_r3_sdin_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sclk) |-> $stable(sdin));

    // R4: minimum deselect time before every frame
    a_r4_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= 8'(GAP_CYC)));

    // R6: group load pulse only while deselected
    a_r6_ldac_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldac_n && run_grp) |-> cs_n);

    // R6: load pulse width
    a_r6_ldac_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ldac_n) && cs_n) |-> (lo_w == 8'(LDAC_W)));

    // R8: a taken set blocks further acceptance on the next cycle
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

endmodule

bind quad_dac_sequencer quad_dac_sequencer_chk #(
    .FW      (FW),
    .GAP_CYC (GAP_CYC),
    .LDAC_W  (LDAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdin      (sdin),
    .ldac_n    (ldac_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .run_grp   (run_grp)
);

// File: tb/quad_dac_sequencer_test.sv
module quad_dac_sequencer_test;
    localparam int H     = 2;
    localparam int GAP   = 17;
    localparam int DLY   = 13;
    localparam int LW    = 2;
    localparam int FRAME = 24 * 2 * H;
    localparam int SPER  = FRAME + GAP;
    localparam int GPER  = 4 * FRAME + 3 * GAP + DLY + LW + GAP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [63:0] smp_codes = '0;
    logic        single_mode = 1'b0;
    logic [3:0]  chan_en = '0;
    logic        sclk, sdin, cs_n, ldac_n;

    always #5 clk = ~clk;

    quad_dac_sequencer #(
        .SCLK_HALF(H), .GAP_CYC(GAP), .LDAC_DLY(DLY), .LDAC_W(LW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_codes(smp_codes), .single_mode(single_mode), .chan_en(chan_en),
        .sclk(sclk), .sdin(sdin), .cs_n(cs_n), .ldac_n(ldac_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // pin-level frame monitor
    int          cyc = 0, nfr = 0, nbits = 0, hi_run = 1000, min_gap = 1000;
    int          sdin_bad = 0, idle_bad = 0, rise_cyc = 0, ld_start = 0;
    int          ld_delay = -1, ld_width = -1;
    bit          ld_cs_ok = 1;
    bit          prev_cs = 1, prev_sclk = 1, prev_sdin = 0, prev_ldac = 1;
    bit          in_ldac_lo = 0, in_rdy = 0;
    logic [23:0] shreg = '0;
    logic [23:0] fr_word [64];
    int          fr_bits [64];
    int          fr_start[64];
    bit          fr_ldac [64];
    bit          fr_rdy  [64];

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_cs && !cs_n) begin
                if (nfr > 0 && hi_run < min_gap) min_gap = hi_run;
                fr_start[nfr] = cyc;
                nbits = 0;
                shreg = '0;
                in_ldac_lo = !ldac_n;
                in_rdy = smp_ready;
            end
            if (!cs_n) begin
                if (prev_sclk && !sclk) begin
                    shreg = {shreg[22:0], sdin};
                    nbits++;
                end
                if (!sclk && !prev_sclk && sdin != prev_sdin) sdin_bad++;
                if (!ldac_n) in_ldac_lo = 1;
                if (smp_ready) in_rdy = 1;
            end else begin
                if (!sclk) idle_bad++;
                hi_run++;
            end
            if (!prev_cs && cs_n && nfr < 64) begin
                fr_word[nfr] = shreg;
                fr_bits[nfr] = nbits;
                fr_ldac[nfr] = in_ldac_lo;
                fr_rdy[nfr]  = in_rdy;
                nfr++;
                rise_cyc = cyc;
                hi_run = 1;
            end
            if (prev_ldac && !ldac_n) begin
                ld_delay = cyc - rise_cyc;
                ld_start = cyc;
                ld_cs_ok = cs_n;
            end
            if (!ldac_n && !cs_n) ld_cs_ok = 0;
            if (!prev_ldac && ldac_n) ld_width = cyc - ld_start;
        end
        prev_cs = cs_n; prev_sclk = sclk; prev_sdin = sdin; prev_ldac = ldac_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic offer(input logic [63:0] codes, input bit single, input logic [3:0] mask);
        smp_codes = codes; single_mode = single; chan_en = mask; smp_valid = 1'b1;
        while (!smp_ready) @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wait_frames(input int n, input int tail);
        while (nfr < n) @(negedge clk);
        repeat (tail) @(negedge clk);
    endtask

    function automatic logic [23:0] expw(input int ch, input logic [63:0] codes);
        return {5'b0, 3'(ch), codes[ch*16 +: 16]};
    endfunction

    task automatic t_reset();
        check(cs_n == 1 && ldac_n == 1 && sclk == 1, "R1", "idle pins", {cs_n, ldac_n, sclk}, 3'b111);
        check(sdin == 0, "R1", "sdin idle", sdin, 0);
        check(smp_ready == 1, "R1", "ready after reset", smp_ready, 1);
        repeat (50) @(negedge clk);
        check(nfr == 0, "R1", "no frame before data", nfr, 0);
    endtask

    task automatic t_group_basic();
        int base = nfr;
        logic [63:0] c = 64'hFFFF_0000_ABCD_1234;
        sdin_bad = 0; idle_bad = 0; min_gap = 1000;
        offer(c, 1'b0, 4'b0010);
        wait_frames(base + 4, DLY + LW + GAP + 10);
        check(nfr == base + 4, "R5", "group frame count", nfr - base, 4);
        for (int i = 0; i < 4; i++) begin
            check(fr_bits[base+i] == 24, "R2", "bits per frame", fr_bits[base+i], 24);
            check(fr_word[base+i] == expw(i, c), "R5", "group word/order", fr_word[base+i], expw(i, c));
            check(fr_ldac[base+i] == 0, "R5", "ldac high in frame", fr_ldac[base+i], 0);
        end
        check(min_gap >= GAP, "R4", "cs gap", min_gap, GAP);
        check(ld_delay == DLY, "R6", "load delay", ld_delay, DLY);
        check(ld_width == LW, "R6", "load width", ld_width, LW);
        check(ld_cs_ok == 1, "R6", "cs high during load", ld_cs_ok, 1);
        check(sdin_bad == 0, "R3", "sdin moved while sclk low", sdin_bad, 0);
        check(idle_bad == 0, "R3", "sclk low while deselected", idle_bad, 0);
        check(fr_start[base+1] - fr_start[base] == FRAME + GAP, "R3", "frame+gap cycles",
              fr_start[base+1] - fr_start[base], FRAME + GAP);
    endtask

    task automatic t_single_one(input logic [3:0] mask, input int ch);
        int base = nfr;
        logic [63:0] c = 64'h4444_3333_2222_1111 ^ {16'(ch), 16'(ch), 16'(ch), 16'(ch)};
        offer(c, 1'b1, mask);
        wait_frames(base + 1, 300);
        check(nfr == base + 1, "R7", "single frame count", nfr - base, 1);
        check(fr_word[base] == expw(ch, c), "R7", "single channel word", fr_word[base], expw(ch, c));
        check(fr_ldac[base] == 1, "R7", "ldac low in frame", fr_ldac[base], 1);
        check(ldac_n == 0, "R7", "ldac held low after", ldac_n, 0);
    endtask

    task automatic t_stream_single();
        int base = nfr;
        for (int k = 0; k < 5; k++) offer({48'h0, 16'h0100 + 16'(k)} << 48, 1'b1, 4'b1000);
        wait_frames(base + 5, 200);
        for (int k = 0; k < 5; k++)
            check(fr_word[base+k] == {8'h03, 16'h0100 + 16'(k)}, "R8", "streamed set order",
                  fr_word[base+k], {8'h03, 16'h0100 + 16'(k)});
        for (int k = 1; k < 5; k++)
            check(fr_start[base+k] - fr_start[base+k-1] == SPER, "R9", "single frame period",
                  fr_start[base+k] - fr_start[base+k-1], SPER);
    endtask

    task automatic t_stream_group();
        int base = nfr;
        logic [63:0] a = 64'h0D0D_0C0C_0B0B_0A0A;
        logic [63:0] b = 64'hF4F4_F3F3_F2F2_F1F1;
        offer(a, 1'b0, 4'b0000);
        offer(b, 1'b0, 4'b1111);
        wait_frames(base + 8, DLY + LW + GAP + 10);
        for (int i = 0; i < 4; i++) begin
            check(fr_word[base+i] == expw(i, a), "R8", "first group intact", fr_word[base+i], expw(i, a));
            check(fr_word[base+4+i] == expw(i, b), "R8", "second group intact", fr_word[base+4+i], expw(i, b));
        end
        check(fr_ldac[base] == 0, "R7", "ldac released on group start", fr_ldac[base], 0);
        for (int i = 0; i < 3; i++)
            check(fr_rdy[base+4+i] == 0, "R8", "not ready mid group", fr_rdy[base+4+i], 0);
        check(fr_start[base+4] - fr_start[base] == GPER, "R9", "group run period",
              fr_start[base+4] - fr_start[base], GPER);
    endtask

    task automatic t_mode_capture();
        int base = nfr;
        logic [63:0] c = 64'h8765_4321_0FED_CBA9;
        offer(c, 1'b0, 4'b0000);
        single_mode = 1'b1; chan_en = 4'b0100;
        wait_frames(base + 4, DLY + LW + GAP + 10);
        check(nfr == base + 4, "R8", "mode captured at accept", nfr - base, 4);
        for (int i = 0; i < 4; i++)
            check(fr_word[base+i] == expw(i, c), "R8", "captured group word", fr_word[base+i], expw(i, c));
        single_mode = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_group_basic();
        t_single_one(4'b0100, 2);
        t_single_one(4'b0110, 1);
        t_single_one(4'b0000, 0);
        t_stream_single();
        t_stream_group();
        t_mode_capture();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule